// File: doc/BRIEF.md
# Dual-Mode Instruction Stream Aligner

This block sits between instruction fetch and decode in a core whose memory image mixes full 32-bit instructions with 16-bit compressed ones. Fetched words arrive one at a time over a valid/ready handshake. The aligner tracks whether the stream is currently in normal or compressed mode. In normal mode each word goes downstream unchanged. In compressed mode each word is split into two halfword slots, issued low slot first.

Mode-switch instructions are taken out of the stream. A normal-mode entry word switches the block to compressed mode from the following word onward. A compressed exit slot returns the block to normal mode. Compressed no-op padding, which keeps the next full instruction on a word boundary, is dropped. Every emitted item carries a tag bit, so the downstream expander knows which items to widen to full instructions before decode.

Top module: `istream_aligner`

## Requirements
- R1: After reset the block is in normal mode with no halfword pending. `out_valid` and `align_err` are low, and `in_ready` equals `out_ready`.
- R2: In normal mode an accepted word that is not an entry word is presented on `out_instr` unchanged, with `out_cmp` = 0, in the same cycle it is offered.
- R3: In normal mode a word whose bits [31:26] equal 6'b111110 is an entry word. It is consumed without any output, and the next word is treated as compressed.
- R4: In compressed mode the low halfword (bits [15:0]) is issued before the high halfword (bits [31:16]). Each is issued in `out_instr[15:0]`, with `out_instr[31:16]` = 0 and `out_cmp` = 1. `in_ready` stays low while the high halfword is pending.
- R5: A compressed slot equal to 16'h0000 is padding. It is dropped and never emitted.
- R6: A compressed slot whose bits [15:10] equal 6'b111111 is an exit. It is consumed without output, and the next fetched word is handled in normal mode.
- R7: An exit in the low slot of a word whose high slot is not 16'h0000 raises `align_err` in the cycle that word is accepted. The high slot is discarded, and the next word is handled in normal mode.
- R8: While `flush` is high, `in_ready` and `out_valid` are low. After a flush cycle the mode is normal and any pending halfword has been discarded.
- R9: While `out_ready` is low, no word is accepted, and a pending high halfword stays on `out_instr` unchanged until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Synchronous flush: back to normal mode, pending halfword discarded |
| in_valid | input | 1 | Fetched word valid |
| in_ready | output | 1 | Aligner accepts the fetched word this cycle |
| in_word | input | 32 | Fetched instruction word |
| out_valid | output | 1 | Instruction item valid |
| out_ready | input | 1 | Downstream takes the item |
| out_instr | output | 32 | Full instruction, or compressed slot zero-extended |
| out_cmp | output | 1 | 1 = compressed item, 0 = full instruction |
| align_err | output | 1 | Exit slot followed by a non-padding halfword in the same word |

## Verification
Mode is the state most likely to go wrong. A wrong mode shows on the next fetched word: it is either passed whole with the wrong tag or split into two halfwords. The bench therefore follows every mode switch with a word whose handling depends on the mode. A stuck or lost pending-halfword flag shows within one cycle: `in_ready` stays low, or the high slot goes missing. For that reason the bench checks `in_ready` and the high slot in the cycle right after each split word.

// File: rtl/ialn_pkg.sv
package ialn_pkg;
  localparam int NRM_W = 32;
  localparam int CMP_W = 16;
  localparam int SLOTS = NRM_W / CMP_W;
  localparam int OP_W  = 6;

  localparam logic [OP_W-1:0]  ENTER_OP = 6'b111110;
  localparam logic [OP_W-1:0]  EXIT_OP  = 6'b111111;
  localparam logic [CMP_W-1:0] PAD_SLOT = '0;

  typedef enum logic {
    MODE_NRM = 1'b0,
    MODE_CMP = 1'b1
  } mode_e;

  typedef struct packed {
    logic pad;
    logic quit;
  } slot_cls_t;
endpackage

// File: rtl/ialn_rst_sync.sv
module ialn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ialn_slot_decode.sv
module ialn_slot_decode
  import ialn_pkg::*;
(
  input  logic [CMP_W-1:0] slot,
  output slot_cls_t        cls
);
  always_comb begin
    cls.pad  = (slot == PAD_SLOT);
    cls.quit = (slot[CMP_W-1 -: OP_W] == EXIT_OP);
  end
endmodule

// File: rtl/ialn_hold_buf.sv
module ialn_hold_buf
  import ialn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic [CMP_W-1:0] d,
  output logic [CMP_W-1:0] q,
  output logic             vld
);
  logic [CMP_W-1:0] data_n;
  logic             vld_n;

  always_comb begin
    data_n = q;
    vld_n  = vld;
    if (clear) begin
      vld_n = 1'b0;
    end else if (load) begin
      data_n = d;
      vld_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      q   <= data_n;
      vld <= vld_n;
    end
  end
endmodule

// File: rtl/istream_aligner.sv
module istream_aligner
  import ialn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NRM_W-1:0] in_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [NRM_W-1:0] out_instr,
  output logic             out_cmp,
  output logic             align_err
);
  localparam int LO = 0;
  localparam int HI = SLOTS - 1;

  logic             rst_sync_n;
  mode_e            mode_q, mode_n;
  slot_cls_t        in_cls [SLOTS];
  slot_cls_t        hold_cls;
  logic [CMP_W-1:0] hold_q;
  logic             hold_vld_q;
  logic             hold_load, hold_clear;
  logic             entry_word, accept;

  ialn_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    ialn_slot_decode u_dec (.slot(in_word[s*CMP_W +: CMP_W]), .cls(in_cls[s]));
  end

  ialn_slot_decode u_hold_dec (.slot(hold_q), .cls(hold_cls));

  ialn_hold_buf u_hold (
    .clk(clk), .rst_n(rst_sync_n), .load(hold_load), .clear(hold_clear),
    .d(in_word[HI*CMP_W +: CMP_W]), .q(hold_q), .vld(hold_vld_q)
  );

  assign entry_word = (in_word[NRM_W-1 -: OP_W] == ENTER_OP);
  assign in_ready   = !flush && !hold_vld_q && out_ready;
  assign accept     = in_valid && in_ready;

  // next-state: mode and pending halfword
  always_comb begin
    mode_n     = mode_q;
    hold_load  = 1'b0;
    hold_clear = 1'b0;
    if (flush) begin
      mode_n     = MODE_NRM;
      hold_clear = 1'b1;
    end else if (hold_vld_q) begin
      if (hold_cls.quit) begin
        mode_n     = MODE_NRM;
        hold_clear = 1'b1;
      end else if (out_ready) begin
        hold_clear = 1'b1;
      end
    end else if (accept) begin
      if (mode_q == MODE_NRM) begin
        if (entry_word) mode_n = MODE_CMP;
      end else if (in_cls[LO].quit) begin
        mode_n = MODE_NRM;
      end else if (!in_cls[HI].pad) begin
        hold_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mode_q <= MODE_NRM;
    else             mode_q <= mode_n;
  end

  // output selection
  always_comb begin
    out_valid = 1'b0;
    out_instr = '0;
    out_cmp   = 1'b0;
    if (!flush) begin
      if (hold_vld_q) begin
        out_valid = !hold_cls.quit;
        out_instr = {{(NRM_W-CMP_W){1'b0}}, hold_q};
        out_cmp   = 1'b1;
      end else if (mode_q == MODE_NRM) begin
        out_valid = in_valid && !entry_word;
        out_instr = in_word;
      end else begin
        out_valid = in_valid && !in_cls[LO].pad && !in_cls[LO].quit;
        out_instr = {{(NRM_W-CMP_W){1'b0}}, in_word[LO*CMP_W +: CMP_W]};
        out_cmp   = 1'b1;
      end
    end
  end

  assign align_err = accept && (mode_q == MODE_CMP) && in_cls[LO].quit && !in_cls[HI].pad;
endmodule

// File: rtl/istream_aligner_chk.sv
module istream_aligner_chk
  import ialn_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [NRM_W-1:0] out_instr,
  input logic             out_cmp,
  input logic             align_err,
  input mode_e            mode_q,
  input logic             hold_vld_q
);
  a_r4_stall_pending: assert property (@(posedge clk) disable iff (!rst_n)
    hold_vld_q |-> !in_ready);

  a_r4_cmp_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cmp) |-> (out_instr[NRM_W-1:CMP_W] == '0));

  a_r3_no_entry_out: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_cmp) |-> (out_instr[NRM_W-1 -: OP_W] != ENTER_OP));

  a_r5_no_pad_out: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cmp) |-> (out_instr[CMP_W-1:0] != PAD_SLOT));

  a_r6_no_exit_out: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cmp) |-> (out_instr[CMP_W-1 -: OP_W] != EXIT_OP));

  a_r7_err_to_normal: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> (mode_q == MODE_NRM) && !hold_vld_q);

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (mode_q == MODE_NRM) && !hold_vld_q);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld_q && out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_instr)));
endmodule

bind istream_aligner istream_aligner_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .flush(flush), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
  .out_cmp(out_cmp), .align_err(align_err), .mode_q(mode_q), .hold_vld_q(hold_vld_q)
);

// File: tb/istream_aligner_bench.sv
module istream_aligner_bench;
  logic        clk = 1'b0;
  logic        rst_n, flush, in_valid, out_ready;
  logic [31:0] in_word;
  logic        in_ready, out_valid, out_cmp, align_err;
  logic [31:0] out_instr;
  int          n_chk = 0, n_bad = 0, cyc = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  istream_aligner u_istream_aligner (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_instr(out_instr), .out_cmp(out_cmp), .align_err(align_err)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic put(logic v, logic [31:0] w);
    in_valid = v; in_word = w;
  endtask

  task automatic expect_out(string req, logic v, logic [31:0] d, logic c, logic rdy);
    check(req, "out_valid", 32'(out_valid), 32'(v));
    if (v) begin
      check(req, "out_instr", out_instr, d);
      check(req, "out_cmp", 32'(out_cmp), 32'(c));
    end
    check(req, "in_ready", 32'(in_ready), 32'(rdy));
  endtask

  task automatic enter_cmp();
    tick(); put(1'b1, 32'hF800_0000); #5;
    expect_out("R3", 1'b0, 32'h0, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    #5;
    expect_out("R1", 1'b0, 32'h0, 1'b0, 1'b1);
    check("R1", "align_err", 32'(align_err), 32'h0);
  endtask

  task automatic t_normal();
    tick(); put(1'b1, 32'h1234_5678); #5;
    expect_out("R2", 1'b1, 32'h1234_5678, 1'b0, 1'b1);
    tick(); put(1'b1, 32'hA5A5_0F0F); #5;
    expect_out("R2", 1'b1, 32'hA5A5_0F0F, 1'b0, 1'b1);
    tick(); put(1'b0, 32'h0);
  endtask

  task automatic t_split();
    enter_cmp();
    tick(); put(1'b1, 32'h1234_0042); #5;
    expect_out("R4", 1'b1, 32'h0000_0042, 1'b1, 1'b1);
    tick(); #5;
    expect_out("R4", 1'b1, 32'h0000_1234, 1'b1, 1'b0);
    tick(); put(1'b0, 32'h0); #5;
    expect_out("R4", 1'b0, 32'h0, 1'b1, 1'b1);
  endtask

  task automatic t_pad();
    tick(); put(1'b1, 32'h2222_0000); #5;
    expect_out("R5", 1'b0, 32'h0, 1'b1, 1'b1);
    tick(); put(1'b1, 32'h0000_3333); #5;
    expect_out("R5", 1'b1, 32'h0000_2222, 1'b1, 1'b0);
    tick(); #5;
    expect_out("R5", 1'b1, 32'h0000_3333, 1'b1, 1'b1);
    tick(); put(1'b0, 32'h0); #5;
    expect_out("R5", 1'b0, 32'h0, 1'b1, 1'b1);
  endtask

  task automatic t_exit_hi();
    tick(); put(1'b1, 32'hFC00_0505); #5;
    expect_out("R6", 1'b1, 32'h0000_0505, 1'b1, 1'b1);
    tick(); put(1'b1, 32'h0000_0007); #5;
    expect_out("R6", 1'b0, 32'h0, 1'b0, 1'b0);
    tick(); #5;
    expect_out("R6", 1'b1, 32'h0000_0007, 1'b0, 1'b1);
    tick(); put(1'b0, 32'h0);
  endtask

  task automatic t_exit_lo();
    enter_cmp();
    tick(); put(1'b1, 32'h0000_FC01); #5;
    expect_out("R6", 1'b0, 32'h0, 1'b0, 1'b1);
    check("R6", "align_err", 32'(align_err), 32'h0);
    tick(); put(1'b1, 32'h1111_2222); #5;
    expect_out("R6", 1'b1, 32'h1111_2222, 1'b0, 1'b1);
    tick(); put(1'b0, 32'h0);
  endtask

  task automatic t_align_err();
    enter_cmp();
    tick(); put(1'b1, 32'h4444_FC00); #5;
    check("R7", "align_err", 32'(align_err), 32'h1);
    expect_out("R7", 1'b0, 32'h0, 1'b0, 1'b1);
    tick(); put(1'b1, 32'h9999_0000); #5;
    check("R7", "align_err", 32'(align_err), 32'h0);
    expect_out("R7", 1'b1, 32'h9999_0000, 1'b0, 1'b1);
    tick(); put(1'b0, 32'h0);
  endtask

  task automatic t_backpressure();
    enter_cmp();
    tick(); out_ready = 1'b0; put(1'b1, 32'h5656_1212); #5;
    expect_out("R9", 1'b1, 32'h0000_1212, 1'b1, 1'b0);
    tick(); out_ready = 1'b1; #5;
    expect_out("R9", 1'b1, 32'h0000_1212, 1'b1, 1'b1);
    tick(); put(1'b0, 32'h0); out_ready = 1'b0; #5;
    expect_out("R9", 1'b1, 32'h0000_5656, 1'b1, 1'b0);
    tick(); #5;
    expect_out("R9", 1'b1, 32'h0000_5656, 1'b1, 1'b0);
    tick(); out_ready = 1'b1; #5;
    expect_out("R9", 1'b1, 32'h0000_5656, 1'b1, 1'b0);
    tick(); put(1'b1, 32'h0000_FC00); #5;
    expect_out("R9", 1'b0, 32'h0, 1'b0, 1'b1);
    tick(); put(1'b1, 32'h0000_0007); #5;
    expect_out("R6", 1'b1, 32'h0000_0007, 1'b0, 1'b1);
    tick(); put(1'b0, 32'h0);
  endtask

  task automatic t_flush();
    enter_cmp();
    tick(); put(1'b1, 32'h7777_6666); #5;
    expect_out("R8", 1'b1, 32'h0000_6666, 1'b1, 1'b1);
    tick(); put(1'b0, 32'h0); flush = 1'b1; #5;
    expect_out("R8", 1'b0, 32'h0, 1'b0, 1'b0);
    tick(); flush = 1'b0; put(1'b1, 32'h0BAD_F00D); #5;
    expect_out("R8", 1'b1, 32'h0BAD_F00D, 1'b0, 1'b1);
    tick(); put(1'b0, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; in_word = '0; out_ready = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_normal();
    t_split();
    t_pad();
    t_exit_hi();
    t_exit_lo();
    t_align_err();
    t_backpressure();
    t_flush();
    repeat (2) tick();
    finish_run();
  end
endmodule